// File: doc/BRIEF.md
# Collision-tolerant candidate bus segment

One stage of a daisy-chained result bus in a massively parallel exhaustive-search engine. Each stage serves a group of four search instances. Every cycle the group offers a 4-bit active-low solution word: a zero bit means that instance hit a candidate, and all ones means nothing was found. The stage forwards traffic that arrives from the previous stage, and it inserts its own candidates only into empty bus slots.

Traffic from upstream always wins. A local candidate that cannot leave at once waits in a four-slot buffer. The buffer records, for each entry, how many cycles that entry has been held back. The count travels with the candidate, so the cycle in which it was found can be recovered further down the chain. The formula is: arrival cycle minus delay minus the number of stages crossed. A delay that reaches its ceiling and a candidate that finds the buffer full both raise a warning bit. That bit rides on the bus and is ORed in at every stage.

With 2^i instances the bus word is i+7 bits wide: an (i-2)-bit group identifier, a 4-bit delay count, the 4 solution bits and one warning bit. Every stage registers the word, so a candidate moves one stage per cycle.

Top module: `cand_bus_seg`

## Requirements
- R1: A non-empty upstream word (solution field not all ones) appears on the downstream outputs one cycle later with the same identifier, delay and solution, and `step` low.
- R2: When the upstream word is empty and the buffer holds entries, the oldest entry leaves one cycle later with identifier `LOCAL_ID`, its stored delay, and `step` high.
- R3: When the upstream word is empty, the buffer is empty and a local candidate arrives, that candidate leaves one cycle later with delay 0 and identifier `LOCAL_ID`.
- R4: The delay carried by a local candidate equals the number of cycles it spent waiting in the buffer.
- R5: The delay count stops at 15 (1111b). A local candidate emitted with delay 15 has its warning bit set.
- R6: The buffer has four slots. A local candidate that arrives while the bus is busy and all four slots are full is discarded. The warning bit of the next output word is set, and the entries already held are unaffected.
- R7: An upstream warning bit is ORed into the downstream warning bit of the following cycle.
- R8: With an empty upstream word, an empty buffer and no local candidate, the next output word has solution 1111b, identifier 0, delay 0, and `step` high.
- R9: A synchronous active-high reset gives solution 1111b, identifier 0, delay 0, warning 0 and `step` low, and empties the buffer.
- R10: Buffered candidates leave in the order in which they arrived.
- R11: In a chain, every candidate reaches the end without loss when no warning is raised. Its origin cycle equals its arrival cycle minus its delay minus the number of stages it crossed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_sol_n | input | 4 | Local group solution word, active low |
| up_id | input | GRP_ID_W | Upstream group identifier |
| up_dly | input | 4 | Upstream delay count |
| up_sol_n | input | 4 | Upstream solution word, all ones = empty |
| up_warn | input | 1 | Upstream warning bit |
| dn_id | output | GRP_ID_W | Downstream group identifier (registered) |
| dn_dly | output | 4 | Downstream delay count (registered) |
| dn_sol_n | output | 4 | Downstream solution word (registered) |
| dn_warn | output | 1 | Downstream warning bit (registered) |
| step | output | 1 | High when the last cycle's upstream slot was empty |

## Verification
The saturation property assumes that an upstream word carrying delay 15 also carries its warning bit, as a correct upstream stage would produce. The stimulus therefore only drives upstream words with small delays, or an idle upstream. The pass-through and warning properties assume that the upstream word is stable for a whole cycle. The bench changes inputs only on the falling edge. The chain run keeps local hit rates low enough that the buffer never overflows. A warning seen there is therefore a genuine fault.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int unsigned CBS_SOL_W = 4;
  localparam int unsigned CBS_DLY_W = 4;

  typedef struct packed {
    logic [CBS_SOL_W-1:0] sol;
    logic [CBS_DLY_W-1:0] dly;
  } cbs_entry_t;

  // saturating increment of a wait count
  function automatic logic [CBS_DLY_W-1:0] dly_step(input logic [CBS_DLY_W-1:0] d);
    return (&d) ? d : d + 1'b1;
  endfunction
endpackage

// File: rtl/cbs_queue.sv
module cbs_queue
  import cbs_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pop,
  input  logic                 push_vld,
  input  logic [CBS_SOL_W-1:0] push_sol,
  output logic                 head_vld,
  output cbs_entry_t           head,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 ovf
);
  logic [CNT_W-1:0] cnt, cnt_pop, cnt_nxt;
  logic             accept;
  cbs_entry_t       ent [DEPTH];
  cbs_entry_t       nxt [DEPTH];
  cbs_entry_t       shf [DEPTH];

  // view of the slots after the head has been removed
  for (genvar g = 0; g < DEPTH; g++) begin : g_shift
    if (g == DEPTH - 1) begin : g_last
      assign shf[g] = '0;
    end else begin : g_mid
      assign shf[g] = ent[g+1];
    end
  end

  always_comb begin
    cnt_pop = pop ? cnt - 1'b1 : cnt;
    accept  = push_vld && (cnt_pop != CNT_W'(DEPTH));
    ovf     = push_vld && !accept;
    cnt_nxt = cnt_pop + CNT_W'(accept);
    for (int k = 0; k < DEPTH; k++) begin
      nxt[k] = '0;
      if (CNT_W'(k) < cnt_pop) begin
        nxt[k].sol = pop ? shf[k].sol : ent[k].sol;
        nxt[k].dly = dly_step(pop ? shf[k].dly : ent[k].dly);
      end else if (accept && (CNT_W'(k) == cnt_pop)) begin
        nxt[k].sol = push_sol;
        nxt[k].dly = CBS_DLY_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      for (int k = 0; k < DEPTH; k++) ent[k] <= '0;
    end else begin
      cnt <= cnt_nxt;
      for (int k = 0; k < DEPTH; k++) ent[k] <= nxt[k];
    end
  end

  assign head_vld = (cnt != '0);
  assign head     = ent[0];
  assign cnt_o    = cnt;
endmodule

// File: rtl/cbs_out_sel.sv
module cbs_out_sel
  import cbs_pkg::*;
#(
  parameter int unsigned          GRP_ID_W = 4,
  parameter logic [GRP_ID_W-1:0] LOCAL_ID = '0
) (
  input  logic                 up_empty,
  input  logic [GRP_ID_W-1:0]  up_id,
  input  logic [CBS_DLY_W-1:0] up_dly,
  input  logic [CBS_SOL_W-1:0] up_sol_n,
  input  logic                 head_vld,
  input  cbs_entry_t           head,
  input  logic                 loc_vld,
  input  logic [CBS_SOL_W-1:0] loc_sol_n,
  output logic [GRP_ID_W-1:0]  nx_id,
  output logic [CBS_DLY_W-1:0] nx_dly,
  output logic [CBS_SOL_W-1:0] nx_sol_n,
  output logic                 sent_sat
);
  always_comb begin
    nx_id    = '0;
    nx_dly   = '0;
    nx_sol_n = '1;
    sent_sat = 1'b0;
    if (!up_empty) begin
      nx_id    = up_id;
      nx_dly   = up_dly;
      nx_sol_n = up_sol_n;
    end else if (head_vld) begin
      nx_id    = LOCAL_ID;
      nx_dly   = head.dly;
      nx_sol_n = head.sol;
      sent_sat = &head.dly;
    end else if (loc_vld) begin
      nx_id    = LOCAL_ID;
      nx_sol_n = loc_sol_n;
    end
  end
endmodule

// File: rtl/cand_bus_seg.sv
module cand_bus_seg
  import cbs_pkg::*;
#(
  parameter int unsigned          GRP_ID_W = 4,
  parameter int unsigned          DEPTH    = 4,
  parameter logic [GRP_ID_W-1:0] LOCAL_ID = GRP_ID_W'(5),
  localparam int unsigned         CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CBS_SOL_W-1:0] loc_sol_n,
  input  logic [GRP_ID_W-1:0]  up_id,
  input  logic [CBS_DLY_W-1:0] up_dly,
  input  logic [CBS_SOL_W-1:0] up_sol_n,
  input  logic                 up_warn,
  output logic [GRP_ID_W-1:0]  dn_id,
  output logic [CBS_DLY_W-1:0] dn_dly,
  output logic [CBS_SOL_W-1:0] dn_sol_n,
  output logic                 dn_warn,
  output logic                 step
);
  logic                 up_empty, loc_vld, direct;
  logic                 head_vld, q_ovf, sent_sat;
  cbs_entry_t           head;
  logic [CNT_W-1:0]     q_cnt;
  logic [GRP_ID_W-1:0]  nx_id;
  logic [CBS_DLY_W-1:0] nx_dly;
  logic [CBS_SOL_W-1:0] nx_sol_n;

  assign up_empty = &up_sol_n;
  assign loc_vld  = ~&loc_sol_n;
  assign direct   = up_empty && !head_vld && loc_vld;

  cbs_queue #(.DEPTH(DEPTH)) queue_i (
    .clk      (clk),
    .rst      (rst),
    .pop      (up_empty && head_vld),
    .push_vld (loc_vld && !direct),
    .push_sol (loc_sol_n),
    .head_vld (head_vld),
    .head     (head),
    .cnt_o    (q_cnt),
    .ovf      (q_ovf)
  );

  cbs_out_sel #(.GRP_ID_W(GRP_ID_W), .LOCAL_ID(LOCAL_ID)) sel_i (
    .up_empty  (up_empty),
    .up_id     (up_id),
    .up_dly    (up_dly),
    .up_sol_n  (up_sol_n),
    .head_vld  (head_vld),
    .head      (head),
    .loc_vld   (loc_vld),
    .loc_sol_n (loc_sol_n),
    .nx_id     (nx_id),
    .nx_dly    (nx_dly),
    .nx_sol_n  (nx_sol_n),
    .sent_sat  (sent_sat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_id    <= '0;
      dn_dly   <= '0;
      dn_sol_n <= '1;
      dn_warn  <= 1'b0;
      step     <= 1'b0;
    end else begin
      dn_id    <= nx_id;
      dn_dly   <= nx_dly;
      dn_sol_n <= nx_sol_n;
      dn_warn  <= up_warn | q_ovf | sent_sat;
      step     <= up_empty;
    end
  end
endmodule

// File: rtl/cand_bus_seg_chk.sv
module cand_bus_seg_chk
  import cbs_pkg::*;
#(
  parameter int unsigned          GRP_ID_W = 4,
  parameter int unsigned          DEPTH    = 4,
  parameter logic [GRP_ID_W-1:0] LOCAL_ID = '0,
  parameter int unsigned          CNT_W    = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [CBS_SOL_W-1:0] loc_sol_n,
  input logic [GRP_ID_W-1:0]  up_id,
  input logic [CBS_DLY_W-1:0] up_dly,
  input logic [CBS_SOL_W-1:0] up_sol_n,
  input logic                 up_warn,
  input logic [GRP_ID_W-1:0]  dn_id,
  input logic [CBS_DLY_W-1:0] dn_dly,
  input logic [CBS_SOL_W-1:0] dn_sol_n,
  input logic                 dn_warn,
  input logic                 step,
  input logic [CNT_W-1:0]     q_cnt
);
  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    !(&up_sol_n) |=> (dn_sol_n == $past(up_sol_n)) && (dn_id == $past(up_id))
                     && (dn_dly == $past(up_dly)) && !step);
  // R3
  direct_send_chk: assert property (@(posedge clk) disable iff (rst)
    (&up_sol_n) && (q_cnt == '0) && !(&loc_sol_n)
      |=> (dn_sol_n == $past(loc_sol_n)) && (dn_dly == '0) && (dn_id == LOCAL_ID) && step);
  // R5
  sat_warn_chk: assert property (@(posedge clk) disable iff (rst)
    !(&dn_sol_n) && (&dn_dly) |-> dn_warn);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    q_cnt <= CNT_W'(DEPTH));
  // R7
  warn_chain_chk: assert property (@(posedge clk) disable iff (rst)
    up_warn |=> dn_warn);
  // R8
  idle_word_chk: assert property (@(posedge clk) disable iff (rst)
    (&up_sol_n) && (&loc_sol_n) && (q_cnt == '0)
      |=> (&dn_sol_n) && (dn_id == '0) && (dn_dly == '0) && step);
endmodule

bind cand_bus_seg cand_bus_seg_chk #(
  .GRP_ID_W (GRP_ID_W),
  .DEPTH    (DEPTH),
  .LOCAL_ID (LOCAL_ID),
  .CNT_W    (CNT_W)
) chk_i (.*);

// File: tb/cand_bus_seg_tb.sv
module cand_bus_seg_tb_top;
  localparam int CLK_P = 10;
  localparam int NCH   = 360;

  typedef struct packed {
    logic [3:0] u_sol; logic [3:0] u_id; logic [3:0] u_dly; logic u_warn; logic [3:0] loc;
    logic [3:0] e_sol; logic [3:0] e_id; logic [3:0] e_dly; logic e_warn; logic e_step;
  } vec_t;

  // R1 R2 R3 R4 R7 R8 R10 walked in order; local identifier 5
  localparam vec_t VEC [9] = '{
    '{4'hF,4'h0,4'h0,1'b0,4'hF, 4'hF,4'h0,4'h0,1'b0,1'b1},
    '{4'hF,4'h0,4'h0,1'b0,4'hE, 4'hE,4'h5,4'h0,1'b0,1'b1},
    '{4'h7,4'h2,4'h3,1'b0,4'hD, 4'h7,4'h2,4'h3,1'b0,1'b0},
    '{4'h3,4'h1,4'h0,1'b0,4'hB, 4'h3,4'h1,4'h0,1'b0,1'b0},
    '{4'hF,4'h0,4'h0,1'b0,4'hF, 4'hD,4'h5,4'h2,1'b0,1'b1},
    '{4'hF,4'h0,4'h0,1'b0,4'h6, 4'hB,4'h5,4'h2,1'b0,1'b1},
    '{4'hF,4'h0,4'h0,1'b0,4'hF, 4'h6,4'h5,4'h1,1'b0,1'b1},
    '{4'hF,4'h0,4'h0,1'b1,4'hF, 4'hF,4'h0,4'h0,1'b1,1'b1},
    '{4'hF,4'h0,4'h0,1'b0,4'hF, 4'hF,4'h0,4'h0,1'b0,1'b1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [3:0] loc_sol_n = 4'hF, up_id = '0, up_dly = '0, up_sol_n = 4'hF;
  logic up_warn = 1'b0;
  logic [3:0] dn_id, dn_dly, dn_sol_n;
  logic dn_warn, step;

  logic [3:0] l0 = 4'hF, l1 = 4'hF;
  logic [3:0] m_id, m_dly, m_sol, e_id, e_dly, e_sol;
  logic m_warn, e_warn, m_step, e_step;
  logic [3:0] f_id, f_dly, f_sol;
  logic f_warn, f_step;

  int tests = 0, fails = 0;
  logic [3:0] h0 [NCH];
  logic [3:0] h1 [NCH];

  always #(CLK_P/2) clk = ~clk;

  cand_bus_seg dut_i (
    .clk(clk), .rst(rst), .loc_sol_n(loc_sol_n), .up_id(up_id), .up_dly(up_dly),
    .up_sol_n(up_sol_n), .up_warn(up_warn), .dn_id(dn_id), .dn_dly(dn_dly),
    .dn_sol_n(dn_sol_n), .dn_warn(dn_warn), .step(step));

  cand_bus_seg #(.LOCAL_ID(4'd1)) c0_i (
    .clk(clk), .rst(rst), .loc_sol_n(l0), .up_id(4'd0), .up_dly(4'd0),
    .up_sol_n(4'hF), .up_warn(1'b0), .dn_id(m_id), .dn_dly(m_dly),
    .dn_sol_n(m_sol), .dn_warn(m_warn), .step(m_step));

  cand_bus_seg #(.LOCAL_ID(4'd2)) c1_i (
    .clk(clk), .rst(rst), .loc_sol_n(l1), .up_id(m_id), .up_dly(m_dly),
    .up_sol_n(m_sol), .up_warn(m_warn), .dn_id(f_id), .dn_dly(f_dly),
    .dn_sol_n(f_sol), .dn_warn(f_warn), .step(f_step));

  task automatic check(input string req, input logic ok, input string got, input string exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %s expected %s", req, got, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] us, input logic [3:0] ui, input logic [3:0] ud,
                     input logic uw, input logic [3:0] lc);
    @(negedge clk);
    up_sol_n = us; up_id = ui; up_dly = ud; up_warn = uw; loc_sol_n = lc;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_word(input string req, input logic [3:0] s, input logic [3:0] i,
                          input logic [3:0] d, input logic w, input logic st);
    check(req, {dn_sol_n, dn_id, dn_dly, dn_warn, step} == {s, i, d, w, st},
          $sformatf("sol=%h id=%h dly=%h warn=%b step=%b", dn_sol_n, dn_id, dn_dly, dn_warn, step),
          $sformatf("sol=%h id=%h dly=%h warn=%b step=%b", s, i, d, w, st));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; up_sol_n = 4'hF; up_id = '0; up_dly = '0; up_warn = 1'b0; loc_sol_n = 4'hF;
    l0 = 4'hF; l1 = 4'hF;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog got running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int n_ok;
    int inj0, inj1, got0, got1;
    logic [15:0] lf;
    // R9 reset state
    @(posedge clk); #1;
    chk_word("R9 reset", 4'hF, 4'h0, 4'h0, 1'b0, 1'b0);
    do_reset();
    for (int v = 0; v < 9; v++) begin
      cyc(VEC[v].u_sol, VEC[v].u_id, VEC[v].u_dly, VEC[v].u_warn, VEC[v].loc);
      e_sol = VEC[v].e_sol; e_id = VEC[v].e_id; e_dly = VEC[v].e_dly;
      e_warn = VEC[v].e_warn; e_step = VEC[v].e_step;
      chk_word($sformatf("R1/R2/R3/R4/R8/R10 row %0d", v), e_sol, e_id, e_dly, e_warn, e_step);
    end

    // R9 reset flushes a held candidate
    cyc(4'h7, 4'h2, 4'h0, 1'b0, 4'hA);
    @(negedge clk); rst = 1'b1; loc_sol_n = 4'hF; up_sol_n = 4'hF;
    @(posedge clk); #1;
    chk_word("R9 reset mid-run", 4'hF, 4'h0, 4'h0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    cyc(4'hF, 4'h0, 4'h0, 1'b0, 4'hF);
    chk_word("R9 buffer emptied", 4'hF, 4'h0, 4'h0, 1'b0, 1'b1);

    // R6 overflow: five candidates under a busy bus
    do_reset();
    for (int k = 0; k < 4; k++) cyc(4'h7, 4'h2, 4'h0, 1'b0, 4'hA);
    chk_word("R6 four held, no warning", 4'h7, 4'h2, 4'h0, 1'b0, 1'b0);
    cyc(4'h7, 4'h2, 4'h0, 1'b0, 4'hA);
    chk_word("R6 fifth dropped with warning", 4'h7, 4'h2, 4'h0, 1'b1, 1'b0);
    cyc(4'hF, 4'h0, 4'h0, 1'b0, 4'hF);
    chk_word("R4 R6 first drained entry", 4'hA, 4'h5, 4'h5, 1'b0, 1'b1);
    n_ok = 1;
    for (int k = 0; k < 5; k++) begin
      cyc(4'hF, 4'h0, 4'h0, 1'b0, 4'hF);
      if (dn_sol_n == 4'hA) n_ok++;
    end
    check("R6 exactly four emitted", n_ok == 4, $sformatf("%0d", n_ok), "4");

    // R5 boundary: 14 cycles held gives 14, no warning
    do_reset();
    cyc(4'h7, 4'h2, 4'h0, 1'b0, 4'hC);
    for (int k = 0; k < 13; k++) cyc(4'h7, 4'h2, 4'h0, 1'b0, 4'hF);
    cyc(4'hF, 4'h0, 4'h0, 1'b0, 4'hF);
    chk_word("R5 below ceiling", 4'hC, 4'h5, 4'hE, 1'b0, 1'b1);
    // R5 saturated: 18 cycles held gives 15 with warning
    do_reset();
    cyc(4'h7, 4'h2, 4'h0, 1'b0, 4'hC);
    for (int k = 0; k < 17; k++) cyc(4'h7, 4'h2, 4'h0, 1'b0, 4'hF);
    cyc(4'hF, 4'h0, 4'h0, 1'b0, 4'hF);
    chk_word("R5 saturated", 4'hC, 4'h5, 4'hF, 1'b1, 1'b1);

    // R11 two-stage chain with sparse pseudo-random hits
    do_reset();
    lf = 16'hACE1;
    inj0 = 0; inj1 = 0; got0 = 0; got1 = 0;
    for (int n = 0; n < NCH; n++) begin
      if (!(&f_sol)) begin
        int org;
        org = n - int'(f_dly) - ((f_id == 4'd1) ? 2 : 1);
        if (f_id == 4'd1) got0++; else got1++;
        check("R11 origin cycle",
              (org >= 0) && (((f_id == 4'd1) ? h0[org] : h1[org]) == f_sol),
              $sformatf("id=%0d sol=%h origin=%0d", f_id, f_sol, org), "matching local hit");
      end
      if (f_warn) check("R11 no warning in chain", 1'b0, "warn=1", "warn=0");
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      l0 = (n < NCH - 40 && lf[2:0] == 3'd0) ? ~(4'b0001 << lf[5:4]) : 4'hF;
      l1 = (n < NCH - 40 && lf[12:10] == 3'd0) ? ~(4'b0001 << lf[15:14]) : 4'hF;
      h0[n] = l0; h1[n] = l1;
      if (l0 != 4'hF) inj0++;
      if (l1 != 4'hF) inj1++;
      @(negedge clk);
    end
    check("R11 stage-0 hits delivered", got0 == inj0, $sformatf("%0d", got0), $sformatf("%0d", inj0));
    check("R11 stage-1 hits delivered", got1 == inj1, $sformatf("%0d", got1), $sformatf("%0d", inj1));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule